// File: doc/BRIEF.md
# Port-Indexed Fault Event Logger

This block records status changes and over-current events raised by a set of downstream port controllers. Each event is packed into a queue entry holding the index of the port that raised it, a two-bit event kind and a timestamp. The timestamp comes from a free-running counter that advances at a rate set by a programmable prescaler. Software-side transport of the log sits outside the block. A consumer drains entries through a show-ahead read interface.

Alongside the log, each port has its own windowed rate counter. It counts that port's over-current events during a fixed window of clock cycles. At every window boundary the count is captured to an output and cleared. A storm flag is raised for any port whose captured count exceeds a programmable threshold. This lets repeated-fault "flapping" be flagged per port rather than per hub.

Top module: `port_event_logger`

## Requirements
- R1: After reset the queue is empty (`rd_vld_o`=0, `fifo_full_o`=0), `overflow_o` is 0, and every windowed count and storm flag is 0.
- R2: An entry is `{port index, kind, timestamp}` from MSB to LSB, with the timestamp in the low TS_W bits and the kind just above it. Kind codes are 0 status change, 1 short, 2 inrush spike, 3 overload. Every event of every kind is logged.
- R3: The timestamp increments once every `presc_i`+1 clock cycles and wraps modulo 2^TS_W without any indication. An entry carries the timestamp value current in the cycle its event was strobed.
- R4: Events strobed in the same cycle by several ports are queued in ascending port-index order, and all of them carry the same timestamp.
- R5: `rd_data_o` shows the oldest entry whenever `rd_vld_o` is 1. A cycle with `rd_en_i` high removes that entry. `rd_en_i` on an empty queue has no effect.
- R6: `fifo_full_o` is high when FIFO_DEPTH entries are held. Same-cycle events that do not fit are dropped, keeping the lowest-indexed ones. Any drop sets `overflow_o`, which stays set until reset.
- R7: A window lasts `win_len_i`+1 cycles from reset. Per port, events of kinds 1 to 3 are counted; kind 0 is not. At each boundary the count, including the boundary cycle's own event, appears on that port's `win_cnt_o` field. The field is CNT_W bits per port, port 0 lowest. The count saturates at 2^CNT_W−1 and is then cleared for the next window.
- R8: At each boundary `storm_o[p]` is set if the captured count of port p is strictly greater than `storm_thr_i`, otherwise cleared. It holds until the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_vld_i | input | NUM_PORTS | Per-port event strobe |
| evt_kind_i | input | NUM_PORTS*2 | Per-port event kind, port 0 in the low bits |
| presc_i | input | PRESC_W | Timestamp prescaler: tick every presc_i+1 cycles |
| win_len_i | input | WIN_W | Window length minus one, in cycles |
| storm_thr_i | input | CNT_W | Storm threshold (alarm when count > threshold) |
| rd_en_i | input | 1 | Pop the head entry |
| rd_vld_o | output | 1 | Queue not empty |
| rd_data_o | output | PIDX_W+2+TS_W | Head entry {port, kind, timestamp} |
| fifo_full_o | output | 1 | Queue holds FIFO_DEPTH entries |
| overflow_o | output | 1 | Sticky: an event was dropped |
| win_cnt_o | output | NUM_PORTS*CNT_W | Captured per-port counts of the last window |
| storm_o | output | NUM_PORTS | Per-port storm alarm |

## Verification
The queue is driven with single strobes, with bursts where several ports fire in one cycle in scrambled positions, and with bursts arriving into a nearly full queue. These separate correct ordering and partial acceptance from wholesale loss or reordering. Timestamps are compared between event pairs a known gap apart, at a slow prescaler and at a fast one past wrap. That catches a wrong tick rate and a wrong wrap. The window counter is swept from zero to beyond saturation events per window around a fixed threshold, with status-only traffic and staggered per-port bursts. These show the count boundary, the strict-greater comparison, clearing between windows and kind filtering.

// File: rtl/evlog_pkg.sv
package evlog_pkg;
  localparam int unsigned KIND_W = 2;
  typedef enum logic [KIND_W-1:0] {
    EV_STATUS   = 2'd0,
    EV_SHORT    = 2'd1,
    EV_INRUSH   = 2'd2,
    EV_OVERLOAD = 2'd3
  } ev_kind_e;
endpackage

// File: rtl/evlog_timebase.sv
module evlog_timebase #(
  parameter int unsigned TS_W    = 16,
  parameter int unsigned PRESC_W = 8,
  parameter int unsigned WIN_W   = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PRESC_W-1:0] presc_i,
  input  logic [WIN_W-1:0]   win_len_i,
  output logic [TS_W-1:0]    ts_o,
  output logic               win_end_o
);
  logic [PRESC_W-1:0] pre_q;
  logic [TS_W-1:0]    ts_q;
  logic [WIN_W-1:0]   win_q;

  assign ts_o      = ts_q;
  assign win_end_o = (win_q >= win_len_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      ts_q  <= '0;
      win_q <= '0;
    end else begin
      if (pre_q >= presc_i) begin
        pre_q <= '0;
        ts_q  <= ts_q + 1'b1;  // silent wrap
      end else begin
        pre_q <= pre_q + 1'b1;
      end
      if (win_end_o) win_q <= '0;
      else           win_q <= win_q + 1'b1;
    end
  end
endmodule

// File: rtl/evlog_fifo.sv
module evlog_fifo #(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned ENTRY_W   = 20
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [NUM_PORTS-1:0]              wr_vld_i,
  input  logic [NUM_PORTS-1:0][ENTRY_W-1:0] wr_data_i,
  input  logic                              rd_en_i,
  output logic                              rd_vld_o,
  output logic [ENTRY_W-1:0]                rd_data_o,
  output logic                              full_o,
  output logic                              drop_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = AW + 1;

  logic [ENTRY_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]      wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]      count_q;

  int unsigned        slot_rank [NUM_PORTS];
  logic [NUM_PORTS-1:0] accept;
  int unsigned        n_acc;
  int unsigned        free_slots;
  logic               pop;

  assign rd_vld_o  = (count_q != '0);
  assign full_o    = (32'(count_q) == DEPTH);
  assign rd_data_o = mem_q[rd_ptr_q];
  assign pop       = rd_en_i && rd_vld_o;

  // rank each strobe by the number of lower-indexed strobes in the same cycle
  always_comb begin
    int unsigned r;
    r          = 0;
    free_slots = DEPTH - 32'(count_q);
    for (int p = 0; p < NUM_PORTS; p++) begin
      slot_rank[p] = r;
      accept[p]    = wr_vld_i[p] && (r < free_slots);
      if (wr_vld_i[p]) r = r + 1;
    end
    n_acc  = (r < free_slots) ? r : free_slots;
    drop_o = |(wr_vld_i & ~accept);
  end

  always_ff @(posedge clk_i) begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (accept[p]) mem_q[wr_ptr_q + AW'(slot_rank[p])] <= wr_data_i[p];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_q + AW'(n_acc);
      if (pop) rd_ptr_q <= rd_ptr_q + 1'b1;
      count_q  <= count_q + CW'(n_acc) - CW'(pop);
    end
  end
endmodule

// File: rtl/evlog_win_cnt.sv
module evlog_win_cnt #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             win_end_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             storm_o
);
  logic [CNT_W-1:0] live_q, cap_q, live_nxt;
  logic             storm_q;

  assign live_nxt = (&live_q) ? live_q : live_q + CNT_W'(inc_i);
  assign cnt_o    = cap_q;
  assign storm_o  = storm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q  <= '0;
      cap_q   <= '0;
      storm_q <= 1'b0;
    end else if (win_end_i) begin
      live_q  <= '0;
      cap_q   <= live_nxt;
      storm_q <= (live_nxt > thr_i);
    end else begin
      live_q  <= live_nxt;
    end
  end
endmodule

// File: rtl/port_event_logger.sv
module port_event_logger #(
  parameter int unsigned NUM_PORTS  = 4,
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned TS_W       = 16,
  parameter int unsigned PRESC_W    = 8,
  parameter int unsigned WIN_W      = 16,
  parameter int unsigned CNT_W      = 8,
  localparam int unsigned PIDX_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int unsigned KW        = evlog_pkg::KIND_W,
  localparam int unsigned ENTRY_W   = PIDX_W + KW + TS_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_PORTS-1:0]       evt_vld_i,
  input  logic [NUM_PORTS*KW-1:0]    evt_kind_i,
  input  logic [PRESC_W-1:0]         presc_i,
  input  logic [WIN_W-1:0]           win_len_i,
  input  logic [CNT_W-1:0]           storm_thr_i,
  input  logic                       rd_en_i,
  output logic                       rd_vld_o,
  output logic [ENTRY_W-1:0]         rd_data_o,
  output logic                       fifo_full_o,
  output logic                       overflow_o,
  output logic [NUM_PORTS*CNT_W-1:0] win_cnt_o,
  output logic [NUM_PORTS-1:0]       storm_o
);
  import evlog_pkg::*;

  logic [TS_W-1:0]                   ts;
  logic                              win_end;
  logic [NUM_PORTS-1:0][ENTRY_W-1:0] entry;
  logic                              drop;
  logic                              ovf_q;

  evlog_timebase #(.TS_W(TS_W), .PRESC_W(PRESC_W), .WIN_W(WIN_W)) u_tb (
    .clk_i, .rst_ni, .presc_i, .win_len_i, .ts_o(ts), .win_end_o(win_end)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    ev_kind_e kind;
    logic     oc_hit;
    assign kind     = ev_kind_e'(evt_kind_i[p*KW +: KW]);
    assign oc_hit   = evt_vld_i[p] && (kind != EV_STATUS);
    assign entry[p] = {PIDX_W'(p), kind, ts};

    evlog_win_cnt #(.CNT_W(CNT_W)) u_win (
      .clk_i, .rst_ni,
      .inc_i    (oc_hit),
      .win_end_i(win_end),
      .thr_i    (storm_thr_i),
      .cnt_o    (win_cnt_o[p*CNT_W +: CNT_W]),
      .storm_o  (storm_o[p])
    );
  end

  evlog_fifo #(.NUM_PORTS(NUM_PORTS), .DEPTH(FIFO_DEPTH), .ENTRY_W(ENTRY_W)) u_fifo (
    .clk_i, .rst_ni,
    .wr_vld_i (evt_vld_i),
    .wr_data_i(entry),
    .rd_en_i,
    .rd_vld_o,
    .rd_data_o,
    .full_o   (fifo_full_o),
    .drop_o   (drop)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ovf_q <= 1'b0;
    else if (drop) ovf_q <= 1'b1;
  end
  assign overflow_o = ovf_q;
endmodule

// File: rtl/port_event_logger_chk.sv
module port_event_logger_chk #(
  parameter int unsigned NUM_PORTS  = 4,
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned TS_W       = 16,
  parameter int unsigned PRESC_W    = 8,
  parameter int unsigned WIN_W      = 16,
  parameter int unsigned CNT_W      = 8,
  localparam int unsigned PIDX_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int unsigned ENTRY_W   = PIDX_W + 2 + TS_W
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [NUM_PORTS-1:0]       evt_vld_i,
  input logic [NUM_PORTS*2-1:0]     evt_kind_i,
  input logic [PRESC_W-1:0]         presc_i,
  input logic [WIN_W-1:0]           win_len_i,
  input logic [CNT_W-1:0]           storm_thr_i,
  input logic                       rd_en_i,
  input logic                       rd_vld_o,
  input logic [ENTRY_W-1:0]         rd_data_o,
  input logic                       fifo_full_o,
  input logic                       overflow_o,
  input logic [NUM_PORTS*CNT_W-1:0] win_cnt_o,
  input logic [NUM_PORTS-1:0]       storm_o
);
  assert_ovf_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);

  assert_ovf_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overflow_o) |-> $past(evt_vld_i != '0));

  assert_full_nonempty_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_full_o |-> rd_vld_o);

  assert_head_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_vld_o && !rd_en_i) |=> (rd_vld_o && $stable(rd_data_o)));

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
    assert_storm_has_count_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      storm_o[p] |-> (win_cnt_o[p*CNT_W +: CNT_W] != '0));
  end
endmodule

bind port_event_logger port_event_logger_chk #(
  .NUM_PORTS(NUM_PORTS), .FIFO_DEPTH(FIFO_DEPTH), .TS_W(TS_W),
  .PRESC_W(PRESC_W), .WIN_W(WIN_W), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/port_event_logger_tb.sv
`timescale 1ns/1ps
module port_event_logger_tb;
  localparam int NP = 4, DEPTH = 8, TSW = 8, PW = 4, WW = 5, CW = 3;
  localparam int EW = 2 + 2 + TSW;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [NP-1:0]   evt_vld_i = '0;
  logic [NP*2-1:0] evt_kind_i = '0;
  logic [PW-1:0]   presc_i = '0;
  logic [WW-1:0]   win_len_i = '0;
  logic [CW-1:0]   storm_thr_i = '0;
  logic            rd_en_i = 1'b0;
  logic            rd_vld_o, fifo_full_o, overflow_o;
  logic [EW-1:0]   rd_data_o;
  logic [NP*CW-1:0] win_cnt_o;
  logic [NP-1:0]   storm_o;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  port_event_logger #(.NUM_PORTS(NP), .FIFO_DEPTH(DEPTH), .TS_W(TSW), .PRESC_W(PW),
                      .WIN_W(WW), .CNT_W(CW)) u_dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input int presc, input int wlen, input int thr);
    rst_ni = 1'b0; evt_vld_i = '0; rd_en_i = 1'b0;
    presc_i = PW'(presc); win_len_i = WW'(wlen); storm_thr_i = CW'(thr);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic pulse(input logic [NP-1:0] m, input logic [NP*2-1:0] k);
    evt_vld_i = m; evt_kind_i = k;
    @(negedge clk_i);
    evt_vld_i = '0;
  endtask

  task automatic pop(input string req, output int port, output int kind, output int ts);
    chk({req, " rd_vld"}, int'(rd_vld_o), 1);
    port = int'(rd_data_o[EW-1 -: 2]);
    kind = int'(rd_data_o[TSW+1 -: 2]);
    ts   = int'(rd_data_o[TSW-1:0]);
    rd_en_i = 1'b1;
    @(negedge clk_i);
    rd_en_i = 1'b0;
  endtask

  function automatic int cnt_of(input int p);
    return int'(win_cnt_o[p*CW +: CW]);
  endfunction

  initial begin
    #1600000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int pt, kd, t0, t1, t2, exp_c;
    // R1 reset state
    do_reset(0, 15, 3);
    @(negedge clk_i);
    chk("R1 rd_vld", int'(rd_vld_o), 0);
    chk("R1 full", int'(fifo_full_o), 0);
    chk("R1 overflow", int'(overflow_o), 0);
    chk("R1 counts", int'(win_cnt_o), 0);
    chk("R1 storm", int'(storm_o), 0);

    // R5 read on empty has no effect; R2 fields for each kind
    rd_en_i = 1'b1; @(negedge clk_i); rd_en_i = 1'b0;
    chk("R5 empty pop", int'(rd_vld_o), 0);
    for (int k = 0; k < 4; k++) begin
      pulse(NP'(1) << (3 - k), (NP*2)'(k) << (2 * (3 - k)));
      pop("R2", pt, kd, t0);
      chk("R2 port", pt, 3 - k);
      chk("R2 kind", kd, k);
      chk("R5 drained", int'(rd_vld_o), 0);
    end

    // R4 same-cycle ordering and shared timestamp
    do_reset(2, 15, 3);
    pulse(4'b1101, {2'd3, 2'd2, 2'd1, 2'd1});
    pop("R4", pt, kd, t0); chk("R4 first port", pt, 0);
    pop("R4", pt, kd, t1); chk("R4 second port", pt, 2); chk("R4 same ts", t1, t0);
    chk("R4 second kind", kd, 2);
    pop("R4", pt, kd, t2); chk("R4 third port", pt, 3); chk("R4 same ts", t2, t0);

    // R3 tick rate and wrap
    do_reset(3, 15, 3);
    repeat (3) @(negedge clk_i);
    pulse(4'b0001, '0);
    repeat (39) @(negedge clk_i);
    pulse(4'b0010, '0);
    pop("R3", pt, kd, t0); pop("R3", pt, kd, t1);
    chk("R3 slow diff", (t1 - t0) & 255, 10);
    do_reset(0, 15, 3);
    pulse(4'b0001, '0);
    repeat (299) @(negedge clk_i);
    pulse(4'b0100, '0);
    pop("R3", pt, kd, t0); pop("R3", pt, kd, t1);
    chk("R3 wrap diff", (t1 - t0) & 255, 44);

    // R6 full, drop, sticky overflow
    do_reset(0, 31, 7);
    pulse(4'b1111, {4{2'd1}});
    pulse(4'b1111, {4{2'd1}});
    chk("R6 full", int'(fifo_full_o), 1);
    chk("R6 no ovf yet", int'(overflow_o), 0);
    pulse(4'b0010, {4{2'd3}});
    chk("R6 ovf set", int'(overflow_o), 1);
    for (int i = 0; i < 8; i++) begin
      pop("R6", pt, kd, t0);
      chk("R6 kept order", pt, i % 4);
      chk("R6 kept kind", kd, 1);
    end
    chk("R6 empty after drain", int'(rd_vld_o), 0);
    chk("R6 ovf sticky", int'(overflow_o), 1);

    // R6 partial acceptance keeps low ports
    do_reset(0, 31, 7);
    pulse(4'b1111, {4{2'd1}});
    pulse(4'b0011, {4{2'd1}});
    pulse(4'b1111, {4{2'd3}});
    chk("R6 partial ovf", int'(overflow_o), 1);
    for (int i = 0; i < 8; i++) begin
      pop("R6", pt, kd, t0);
      chk("R6 partial port", pt, (i < 4) ? i : (i % 2));
      chk("R6 partial kind", kd, (i < 6) ? 1 : 3);
    end
    chk("R6 partial drained", int'(rd_vld_o), 0);

    // R7/R8 sweep of events per window on port 1, threshold 3
    for (int n = 0; n <= 9; n++) begin
      do_reset(0, 15, 3);
      for (int i = 0; i < n; i++) pulse(4'b0010, {4{2'd2}});
      repeat (16 - n) @(negedge clk_i);
      exp_c = (n > 7) ? 7 : n;
      chk("R7 captured count", cnt_of(1), exp_c);
      chk("R7 other port", cnt_of(0), 0);
      chk("R8 storm", int'(storm_o[1]), int'(exp_c > 3));
      repeat (16) @(negedge clk_i);
      chk("R7 cleared", cnt_of(1), 0);
      chk("R8 storm cleared", int'(storm_o[1]), 0);
    end

    // R7 status changes not counted; staggered per-port bursts, threshold 2
    do_reset(0, 15, 2);
    for (int c = 0; c < 4; c++) begin
      logic [NP-1:0] m;
      for (int p = 0; p < NP; p++) m[p] = (c <= p);
      pulse(m, {2'd3, 2'd1, 2'd2, 2'd0});
    end
    repeat (12) @(negedge clk_i);
    chk("R7 status ignored", cnt_of(0), 0);
    chk("R7 port1", cnt_of(1), 2);
    chk("R7 port2", cnt_of(2), 3);
    chk("R7 port3", cnt_of(3), 4);
    chk("R8 storm map", int'(storm_o), 4'b1100);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule